// File: doc/BRIEF.md
# Four-Channel TDM PCM Serial Port

This block carries 8-bit companded voice samples for four channels across one shared serial line. A frame sync pulse marks the start of each frame. The block then serialises four parallel transmit bytes, MSB first and in channel order, onto a data bit with a separate active-high output enable. On the same bit clock it deserialises four receive bytes from a serial input. The frame is 256 bit clocks long at 2.048 MHz with an 8 kHz sync, but only the first 32 bit times carry data.

Each channel has its own power enable. A disabled channel leaves its 8-bit transmit slot undriven, and so does everything from the 33rd bit clock until the next sync. On the transmit side, parallel data enters through a valid/ready handshake. `tx_ready` is high only in the cycle in which a new frame start is seen, and a word accepted in that cycle becomes the frame's content. If `tx_valid` is low at frame start, the previous word is sent again. The receive side has no back-pressure. `rx_valid` pulses once per complete frame, and `rx_data` holds its value until the next pulse, so the consumer must take it within one frame.

Top module: `pcm_tdm_port`

## Requirements
- R1: After reset `tx_oe` and `rx_valid` are low and `rx_data` is all zeros.
- R2: A frame starts on the rising clock edge at which `fsync` is high after having been low on the previous edge. `tx_ready` equals that condition combinationally. The same edge drives bit 7 of channel 0 (`tx_data[7]`) onto `tx_bit`, and loads the word if `tx_valid` is high.
- R3: Counting the frame-start edge as edge 1, channel c (byte `tx_data[8c+7:8c]`) is driven MSB first on edges 8c+1 to 8c+8, one bit per rising edge.
- R4: From edge 33 until the next frame start, `tx_oe` is low.
- R5: The enable for a slot follows `pwr_en[c]` as sampled at each launch edge. While it is low, `tx_oe` stays low for that channel's slot.
- R6: A change of `tx_data` after frame start does not alter the frame in progress. A frame started with `tx_valid` low repeats the last accepted word.
- R7: Receive bit n of the frame (n = 0..31) is sampled from `rx_in` on the falling edge that follows rising edge n+1. The first bit captured is bit 7 of channel 0, and byte c appears in `rx_data[8c+7:8c]`.
- R8: `rx_valid` is high for exactly one cycle, starting at rising edge 33, with the new `rx_data` on the same cycle.
- R9: Receive bits after the 32nd bit of a frame are ignored. `rx_data` is unchanged and no further `rx_valid` occurs.
- R10: A frame start before the frame ends restarts transmit and receive at bit 0 of channel 0. The interrupted partial frame produces no `rx_valid`.
- R11: Holding `fsync` high for several edges starts only one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; transmit launches on rising edges, receive samples on falling edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, rising level sampled on clock rising edge |
| pwr_en | input | 4 | Per-channel power enable, bit c for channel c |
| tx_data | input | 32 | Four transmit bytes, channel c in bits 8c+7:8c |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | High in the frame-start cycle; handshake loads the word |
| tx_bit | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Active-high enable for `tx_bit` (low means high impedance) |
| rx_in | input | 1 | Serial receive data |
| rx_data | output | 32 | Last complete received frame, channel c in bits 8c+7:8c |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is updated |

## Verification
The end of one frame's receive and the start of the next frame can land on the same rising edge. This happens when the sync is raised so that the restart edge is edge 33. On that edge `rx_valid` must pulse with the completed word, and channel 0's MSB of the new frame must go out. The bench provokes this by driving `fsync` high during bit time 32. It then checks `rx_valid`, `rx_data` and the transmitted stream in that cycle and the cycles after it against its own frame model.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;
  parameter int unsigned DEF_NUM_CH = 4;
  parameter int unsigned DEF_SLOT_W = 8;

  function automatic int unsigned pos_width(input int unsigned frame_bits);
    return $clog2(frame_bits + 1);
  endfunction
endpackage

// File: rtl/pcm_tdm_timer.sv
module pcm_tdm_timer
  import pcm_tdm_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned SLOT_W = DEF_SLOT_W,
  localparam int unsigned FRAME_BITS = NUM_CH * SLOT_W,
  localparam int unsigned CNT_W = pos_width(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic             start,
  output logic [CNT_W-1:0] pos,
  output logic [CNT_W-1:0] next_pos
);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(FRAME_BITS);

  logic fsync_q;

  // frame begins only on a low-to-high sync transition
  assign start = fsync & ~fsync_q;

  always_comb begin
    if (start)            next_pos = '0;
    else if (pos == IDLE) next_pos = IDLE;
    else                  next_pos = pos + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsync_q <= 1'b0;
      pos     <= IDLE;
    end else begin
      fsync_q <= fsync;
      pos     <= next_pos;
    end
  end

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && !fsync_q) |=> (pos == '0));
endmodule

// File: rtl/pcm_tdm_tx.sv
module pcm_tdm_tx
  import pcm_tdm_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned SLOT_W = DEF_SLOT_W,
  localparam int unsigned FRAME_BITS = NUM_CH * SLOT_W,
  localparam int unsigned CNT_W = pos_width(FRAME_BITS),
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned FB_W  = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CNT_W-1:0]      next_pos,
  input  logic [FRAME_BITS-1:0] tx_data,
  input  logic                  tx_valid,
  input  logic [NUM_CH-1:0]     pwr_en,
  output logic                  tx_bit,
  output logic                  tx_oe
);
  logic [FRAME_BITS-1:0] shadow_q;
  logic [FRAME_BITS-1:0] src;
  logic [FRAME_BITS-1:0] ser_order;
  logic                  take;
  logic                  in_frame;
  logic [CH_W-1:0]       ch;
  logic [FB_W-1:0]       idx;

  assign take = start & tx_valid;
  assign src  = take ? tx_data : shadow_q;

  // reorder so that serial position p maps to bit p (slot-major, MSB first)
  for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
    for (genvar k = 0; k < SLOT_W; k++) begin : g_bit
      assign ser_order[c*SLOT_W + k] = src[c*SLOT_W + (SLOT_W-1-k)];
    end
  end

  assign in_frame = next_pos < CNT_W'(FRAME_BITS);
  assign ch       = CH_W'(next_pos / CNT_W'(SLOT_W));
  assign idx      = FB_W'(next_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      tx_oe    <= 1'b0;
      tx_bit   <= 1'b0;
    end else begin
      if (take) shadow_q <= tx_data;
      tx_oe  <= in_frame & pwr_en[ch];
      tx_bit <= in_frame & pwr_en[ch] & ser_order[idx];
    end
  end

  assert_start_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && tx_valid) |=> ((tx_oe == $past(pwr_en[0])) &&
                             (!tx_oe || (tx_bit == $past(tx_data[SLOT_W-1])))));
endmodule

// File: rtl/pcm_tdm_rx.sv
module pcm_tdm_rx
  import pcm_tdm_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned SLOT_W = DEF_SLOT_W,
  localparam int unsigned FRAME_BITS = NUM_CH * SLOT_W,
  localparam int unsigned CNT_W = pos_width(FRAME_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      pos,
  input  logic                  rx_in,
  output logic [FRAME_BITS-1:0] rx_data,
  output logic                  rx_valid
);
  logic [FRAME_BITS-1:0] shift_q;
  logic [FRAME_BITS-1:0] by_chan;
  logic                  last;

  // receive samples mid-bit on the falling edge, only inside the data window
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)                         shift_q <= '0;
    else if (pos < CNT_W'(FRAME_BITS))  shift_q <= {shift_q[FRAME_BITS-2:0], rx_in};
  end

  // first captured bit is oldest: it lands in the top of the shifter
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign by_chan[c*SLOT_W +: SLOT_W] = shift_q[FRAME_BITS-1-c*SLOT_W -: SLOT_W];
  end

  assign last = (pos == CNT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= last;
      if (last) rx_data <= by_chan;
    end
  end

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port
  import pcm_tdm_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned SLOT_W = DEF_SLOT_W,
  localparam int unsigned FRAME_BITS = NUM_CH * SLOT_W,
  localparam int unsigned CNT_W = pos_width(FRAME_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fsync,
  input  logic [NUM_CH-1:0]     pwr_en,
  input  logic [FRAME_BITS-1:0] tx_data,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  output logic                  tx_bit,
  output logic                  tx_oe,
  input  logic                  rx_in,
  output logic [FRAME_BITS-1:0] rx_data,
  output logic                  rx_valid
);
  logic             start;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] next_pos;

  pcm_tdm_timer #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .start(start), .pos(pos), .next_pos(next_pos)
  );

  pcm_tdm_tx #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .next_pos(next_pos),
    .tx_data(tx_data), .tx_valid(tx_valid), .pwr_en(pwr_en),
    .tx_bit(tx_bit), .tx_oe(tx_oe)
  );

  pcm_tdm_rx #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .pos(pos), .rx_in(rx_in),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  assign tx_ready = start;

  assert_float_after_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == CNT_W'(FRAME_BITS)) |-> !tx_oe);

  assert_no_valid_mid_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pos < CNT_W'(FRAME_BITS - 1) && pos != '0) |-> !rx_valid);
endmodule

// File: tb/pcm_tdm_port_tb_top.sv
module pcm_tdm_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic [3:0]  pwr_en = 4'hF;
  logic [31:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, tx_bit, tx_oe, rx_valid;
  logic        rx_in = 1'b0;
  logic [31:0] rx_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] shadow_m = '0;

  always #5 clk = ~clk;

  pcm_tdm_port dut_i (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .pwr_en(pwr_en),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_bit(tx_bit), .tx_oe(tx_oe), .rx_in(rx_in),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one bit time: rising edge, drive inputs, then sample before falling edge
  task automatic step(input bit fs, input bit rb);
    @(posedge clk);
    #1;
    fsync = fs;
    rx_in = rb;
    #3;
  endtask

  // frame model: sync step, then nsteps bit times checked against the requirements
  task automatic run_frame(input logic [31:0] txw, input logic [31:0] rxw,
                           input logic [3:0] pw, input bit load, input int sync_at,
                           input int hold, input int poke_at, input int nsteps,
                           input string req);
    int tx_err = 0;
    int v_err = 0;
    int d_err = 0;
    int prev_idx = -1;
    pwr_en   = pw;
    tx_data  = txw;
    tx_valid = load;
    step(1'b1, 1'b0);
    check(tx_ready === 1'b1, "R2", "tx_ready at frame start", {31'd0, tx_ready}, 32'd1);
    if (load) shadow_m = txw;
    for (int k = 1; k <= nsteps; k++) begin
      int  idx;
      bit  fs, rb, e_oe, e_bit, e_v;
      idx = (sync_at != 0 && k > sync_at) ? k - sync_at - 1 : k - 1;
      fs  = (k == sync_at) || (k <= hold);
      rb  = (idx < 32) ? rxw[8*(idx/8) + 7 - idx%8] : k[0];
      step(fs, rb);
      if (k == 1) tx_valid = 1'b0;
      if (k == poke_at) tx_data = ~txw;
      e_oe  = (idx < 32) && pw[idx/8];
      e_bit = (idx < 32) ? shadow_m[8*(idx/8) + 7 - idx%8] : 1'b0;
      if (tx_oe !== e_oe || (e_oe && tx_bit !== e_bit)) tx_err++;
      e_v = (prev_idx == 31);
      if (rx_valid !== e_v) v_err++;
      if (e_v && rx_data !== rxw) d_err++;
      prev_idx = idx;
    end
    tx_data = txw;
    check(tx_err == 0, req, "transmit slot mismatches", tx_err, 0);
    check(v_err == 0, "R8", "rx_valid timing mismatches", v_err, 0);
    check(d_err == 0, "R7", "received word mismatches", d_err, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step(1'b0, 1'b0);
    check(tx_oe === 1'b0, "R1", "tx_oe in reset", {31'd0, tx_oe}, 0);
    check(rx_valid === 1'b0, "R1", "rx_valid in reset", {31'd0, rx_valid}, 0);
    check(rx_data === 32'd0, "R1", "rx_data in reset", rx_data, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) step(1'b0, 1'b0);
  endtask

  task automatic t_basic();
    run_frame(32'hA5C3_0F96, 32'h1234_5678, 4'hF, 1'b1, 0, 0, 0, 45, "R3 R4");
  endtask

  task automatic t_powerdown();
    run_frame(32'hFFFF_FFFF, 32'h8001_7EE7, 4'b1010, 1'b1, 0, 0, 0, 40, "R5");
    run_frame(32'h5A5A_5A5A, 32'h0F0F_F0F0, 4'b0001, 1'b1, 0, 0, 0, 40, "R5");
  endtask

  task automatic t_shadow();
    run_frame(32'h3C96_E187, 32'hDEAD_BEEF, 4'hF, 1'b1, 0, 0, 6, 40, "R6");
    run_frame(32'h0000_0000, 32'hCAFE_F00D, 4'hF, 1'b0, 0, 0, 0, 40, "R6");
  endtask

  task automatic t_ignore();
    run_frame(32'h1111_2222, 32'h6B3D_92C4, 4'hF, 1'b1, 0, 0, 0, 60, "R4");
    check(rx_data === 32'h6B3D_92C4, "R9", "rx_data after trailing bits", rx_data, 32'h6B3D_92C4);
  endtask

  task automatic t_restart();
    run_frame(32'h7E81_24DB, 32'h55AA_33CC, 4'hF, 1'b1, 12, 0, 0, 50, "R10");
  endtask

  task automatic t_hold();
    run_frame(32'h9C63_A50F, 32'h0123_4567, 4'b0111, 1'b1, 0, 3, 0, 40, "R11");
  endtask

  task automatic t_coincide();
    run_frame(32'hB4E1_7298, 32'hF00F_0FF0, 4'hF, 1'b1, 32, 0, 0, 70, "R10");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_powerdown();
    t_shadow();
    t_ignore();
    t_restart();
    t_hold();
    t_coincide();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule